// File: doc/BRIEF.md
# Dimension-Order Mesh Route Computation

This block is the routing stage that sits behind one input of a two-dimensional mesh router. Each arriving packet header carries two signed hop counts: one for the horizontal axis and one for the vertical axis. These counts say how far the packet still has to travel. From them the block picks exactly one of five output directions: west, east, south, north, or delivery to the attached processor. The horizontal axis is always cleared first, so a route is a horizontal run, at most one turn, and then a vertical run.

The block also rewrites the header so that the next router sees the distance that remains. It moves the hop count of the axis being travelled one step toward zero. The other axis and the payload bits pass through unchanged. The direction request and the rewritten header are registered. They stay on the outputs until the downstream switch acknowledges them.

Top module: `xy_route_unit`

## Requirements
- R1: Header layout is horizontal offset in bits [3:0], vertical offset in bits [7:4] (both 4-bit two's complement), payload in bits [15:8]. Request encoding is one-hot: bit0 local, bit1 west, bit2 east, bit3 south, bit4 north. A negative horizontal offset requests west.
- R2: A positive horizontal offset requests east.
- R3: A zero horizontal offset with a negative vertical offset requests south.
- R4: A zero horizontal offset with a positive vertical offset requests north.
- R5: When both offsets are zero, the request is for the local port.
- R6: While the horizontal offset is nonzero, the vertical offset in the output header equals the incoming one.
- R7: The offset of the axis being travelled moves one step toward zero. The other offset and the payload are copied unchanged. A local delivery passes the whole header through unchanged.
- R8: The request and the rewritten header appear one clock after an accepted header-valid strobe, and never in the same cycle. The request always has at most one bit set.
- R9: While a request is held and acknowledge is low, the outputs do not change, and a header-valid strobe is ignored.
- R10: Acknowledge without a strobe clears the request and the output header to zero on the next clock. Acknowledge together with a strobe replaces the held result with the new one.
- R11: After reset, the request and the output header are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hdr_valid | input | 1 | Strobe: hdr_in holds a new header |
| hdr_in | input | 16 | Incoming header: offsets and payload |
| ack | input | 1 | Downstream has taken the held request |
| port_req | output | 5 | One-hot output direction request |
| hdr_out | output | 16 | Header with the travelled offset stepped |

## Verification
The assertions assume that offsets are legal 4-bit two's-complement values. They also assume that acknowledge is only meaningful while a request is held. An acknowledge on an idle block simply leaves the outputs at zero. The stimulus draws both offsets across the full range from -8 to +7, including both extremes and the zero cases. It raises acknowledge only after checking a held result, or together with a strobe on purpose to exercise replacement. Strobes that arrive while a result is held are driven deliberately, to show that they are ignored.

// File: rtl/xy_route_pkg.sv
// Package: shared constants for the dimension-order route unit.
// Assumes: the direction request is one-hot, with the bit order fixed below.
package xy_route_pkg;
    localparam int NUM_PORTS = 5;
    localparam int P_LOCAL   = 0;
    localparam int P_WEST    = 1;
    localparam int P_EAST    = 2;
    localparam int P_SOUTH   = 3;
    localparam int P_NORTH   = 4;
    localparam int NUM_DIMS  = 2;
endpackage

// File: rtl/xy_port_select.sv
// Module: xy_port_select
// Chooses the output direction from the signed offsets, clearing X before Y.
// Assumes: the offsets are two's complement, OFF_W bits wide. The logic is purely combinational.
module xy_port_select
    import xy_route_pkg::*;
#(
    parameter int OFF_W = 4
) (
    input  logic [OFF_W-1:0]     dx,
    input  logic [OFF_W-1:0]     dy,
    output logic [NUM_PORTS-1:0] port_oh
);
    logic dx_nz, dy_nz, dx_neg, dy_neg;

    // Purpose: classify each offset as zero, negative or positive.
    always_comb begin
        dx_nz  = |dx;
        dy_nz  = |dy;
        dx_neg = dx[OFF_W-1];
        dy_neg = dy[OFF_W-1];
    end

    // Purpose: X takes precedence; Y is used only once X is exhausted.
    always_comb begin
        port_oh = '0;
        if (dx_nz) begin
            if (dx_neg) port_oh[P_WEST] = 1'b1;
            else        port_oh[P_EAST] = 1'b1;
        end else if (dy_nz) begin
            if (dy_neg) port_oh[P_SOUTH] = 1'b1;
            else        port_oh[P_NORTH] = 1'b1;
        end else begin
            port_oh[P_LOCAL] = 1'b1;
        end
    end
endmodule

// File: rtl/xy_offset_step.sv
// Module: xy_offset_step
// Moves the offset of the travelled axis one step toward zero; the other offset passes through.
// Assumes: port_oh has at most one bit set. A nonzero offset never needs more than one step per hop.
module xy_offset_step
    import xy_route_pkg::*;
#(
    parameter int OFF_W = 4
) (
    input  logic [OFF_W-1:0]     dx,
    input  logic [OFF_W-1:0]     dy,
    input  logic [NUM_PORTS-1:0] port_oh,
    output logic [OFF_W-1:0]     dx_next,
    output logic [OFF_W-1:0]     dy_next
);
    localparam logic [OFF_W-1:0] ONE = {{(OFF_W-1){1'b0}}, 1'b1};

    logic [OFF_W-1:0] cur [NUM_DIMS];
    logic [OFF_W-1:0] nxt [NUM_DIMS];
    logic [NUM_DIMS-1:0] move;

    // Purpose: gather the per-dimension inputs and the move enables.
    always_comb begin
        cur[0]  = dx;
        cur[1]  = dy;
        move[0] = port_oh[P_WEST]  | port_oh[P_EAST];
        move[1] = port_oh[P_SOUTH] | port_oh[P_NORTH];
    end

    for (genvar d = 0; d < NUM_DIMS; d++) begin : g_dim
        // Purpose: step one dimension toward zero when it is the one being travelled.
        always_comb begin
            if (!move[d])              nxt[d] = cur[d];
            else if (cur[d][OFF_W-1])  nxt[d] = cur[d] + ONE;
            else                       nxt[d] = cur[d] - ONE;
        end
    end

    // Purpose: drive the stepped offsets out.
    always_comb begin
        dx_next = nxt[0];
        dy_next = nxt[1];
    end
endmodule

// File: rtl/xy_route_hold.sv
// Module: xy_route_hold
// Registers the request and header and holds them until they are acknowledged.
// Assumes: a result is loaded only when nothing is held or an acknowledge arrives in the same cycle.
module xy_route_hold
    import xy_route_pkg::*;
#(
    parameter int HDR_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 ack,
    input  logic [NUM_PORTS-1:0] req_d,
    input  logic [HDR_W-1:0]     hdr_d,
    output logic [NUM_PORTS-1:0] req_q,
    output logic [HDR_W-1:0]     hdr_q,
    output logic                 busy,
    output logic                 load_en
);
    // Purpose: a request is held whenever any request bit is set.
    always_comb busy = |req_q;

    // Purpose: accept a new header when idle, or when the held one is acknowledged.
    always_comb load_en = load && (!busy || ack);

    // Purpose: output registers, with load taking priority over clear and hold as the default.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
            hdr_q <= '0;
        end else if (load_en) begin
            req_q <= req_d;
            hdr_q <= hdr_d;
        end else if (ack) begin
            req_q <= '0;
            hdr_q <= '0;
        end
    end

    // R8: the request never carries more than one bit
    p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_q));

    // R8: an accepted header yields a request on the next clock
    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (req_q != '0));

    // R9: a held result stays unchanged until it is acknowledged
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ack) |=> ($stable(req_q) && $stable(hdr_q)));

    // R10: an acknowledge without a new header clears the outputs
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !load) |=> ((req_q == '0) && (hdr_q == '0)));
endmodule

// File: rtl/xy_route_unit.sv
// Module: xy_route_unit (top)
// Per-input dimension-order route computation for a 2D mesh with relative addressing.
// Assumes: header = {payload, dy, dx}, each offset OFF_W bits of two's complement.
module xy_route_unit
    import xy_route_pkg::*;
#(
    parameter int OFF_W     = 4,
    parameter int PAYLOAD_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           hdr_valid,
    input  logic [2*OFF_W+PAYLOAD_W-1:0]   hdr_in,
    input  logic                           ack,
    output logic [NUM_PORTS-1:0]           port_req,
    output logic [2*OFF_W+PAYLOAD_W-1:0]   hdr_out
);
    localparam int HDR_W  = 2*OFF_W + PAYLOAD_W;
    localparam int DX_LSB = 0;
    localparam int DY_LSB = OFF_W;
    localparam int PL_LSB = 2*OFF_W;

    logic [OFF_W-1:0]     dx_in, dy_in, dx_nx, dy_nx;
    logic [PAYLOAD_W-1:0] pl_in;
    logic [NUM_PORTS-1:0] sel_oh;
    logic [HDR_W-1:0]     hdr_nx;
    logic                 busy, load_en;

    // Purpose: split the incoming header into its fields.
    always_comb begin
        dx_in = hdr_in[DX_LSB +: OFF_W];
        dy_in = hdr_in[DY_LSB +: OFF_W];
        pl_in = hdr_in[PL_LSB +: PAYLOAD_W];
    end

    xy_port_select #(.OFF_W(OFF_W)) u_sel (
        .dx      (dx_in),
        .dy      (dy_in),
        .port_oh (sel_oh)
    );

    xy_offset_step #(.OFF_W(OFF_W)) u_step (
        .dx      (dx_in),
        .dy      (dy_in),
        .port_oh (sel_oh),
        .dx_next (dx_nx),
        .dy_next (dy_nx)
    );

    // Purpose: reassemble the header with the stepped offsets.
    always_comb hdr_nx = {pl_in, dy_nx, dx_nx};

    xy_route_hold #(.HDR_W(HDR_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (hdr_valid),
        .ack     (ack),
        .req_d   (sel_oh),
        .hdr_d   (hdr_nx),
        .req_q   (port_req),
        .hdr_q   (hdr_out),
        .busy    (busy),
        .load_en (load_en)
    );

    // R6: while X is still open, the Y offset leaves the router untouched
    p_x_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && (dx_in != '0)) |=> (hdr_out[DY_LSB +: OFF_W] == $past(dy_in)));

    // R7: the payload is carried across the hop unchanged
    p_payload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (hdr_out[PL_LSB +: PAYLOAD_W] == $past(pl_in)));

    // R5: a local delivery leaves both offsets at zero
    p_local_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && (dx_in == '0) && (dy_in == '0)) |=>
        (port_req[P_LOCAL] && (hdr_out[2*OFF_W-1:0] == '0)));
endmodule

// File: tb/tb_xy_route_unit.sv
`timescale 1ns/1ps
module tb_xy_route_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hdr_valid = 1'b0;
    logic [15:0] hdr_in = '0;
    logic        ack = 1'b0;
    logic [4:0]  port_req;
    logic [15:0] hdr_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    xy_route_unit dut (
        .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_in(hdr_in),
        .ack(ack), .port_req(port_req), .hdr_out(hdr_out)
    );

    always #2 clk = ~clk;

    // Expected one-hot request: bit0 local, 1 west, 2 east, 3 south, 4 north
    function automatic logic [4:0] exp_port(input logic [15:0] h);
        logic signed [3:0] x, y;
        x = h[3:0]; y = h[7:4];
        if (x < 0)      return 5'b00010;
        else if (x > 0) return 5'b00100;
        else if (y < 0) return 5'b01000;
        else if (y > 0) return 5'b10000;
        else            return 5'b00001;
    endfunction

    function automatic logic [15:0] exp_hdr(input logic [15:0] h);
        logic signed [3:0] x, y;
        x = h[3:0]; y = h[7:4];
        if (x != 0)      x = (x < 0) ? x + 4'sd1 : x - 4'sd1;
        else if (y != 0) y = (y < 0) ? y + 4'sd1 : y - 4'sd1;
        return {h[15:8], y, x};
    endfunction

    function automatic string port_tag(input logic [4:0] p);
        case (p)
            5'b00010: return "R1";
            5'b00100: return "R2";
            5'b01000: return "R3";
            5'b10000: return "R4";
            default:  return "R5";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Load one header, check the result, then acknowledge and check the clear
    task automatic send(input logic [15:0] h);
        @(negedge clk);
        hdr_valid = 1'b1; hdr_in = h;
        check("R8 no same-cycle request", 32'(port_req), 32'd0);
        @(negedge clk);
        hdr_valid = 1'b0;
        check(port_tag(exp_port(h)), 32'(port_req), 32'(exp_port(h)));
        check("R7 header step", 32'(hdr_out), 32'(exp_hdr(h)));
        if (h[3:0] != 4'd0) check("R6 y kept", 32'(hdr_out[7:4]), 32'(h[7:4]));
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        check("R10 clear", {11'd0, port_req, hdr_out}, 32'd0);
    endtask

    initial begin
        logic [15:0] a, b;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R11 reset", {11'd0, port_req, hdr_out}, 32'd0);
        rst_n = 1'b1;

        // Directed corners
        send({8'hA5, 4'd5, 4'hD});   // dx=-3, dy=5
        send({8'h3C, 4'hC, 4'd2});   // dx=2, dy=-4
        send({8'h11, 4'hF, 4'd0});   // dy=-1
        send({8'h22, 4'd6, 4'd0});   // dy=6
        send({8'h77, 4'd0, 4'd0});   // local
        send({8'h00, 4'h8, 4'h8});   // -8,-8
        send({8'hFF, 4'd7, 4'd7});   // 7,7
        send({8'h01, 4'd0, 4'd1});
        send({8'h02, 4'd0, 4'hF});
        send({8'h03, 4'h8, 4'd0});
        send({8'h04, 4'd7, 4'd0});

        // R9: strobes while held are ignored
        a = {8'h5A, 4'd3, 4'hE};
        b = {8'hC3, 4'd0, 4'd0};
        @(negedge clk); hdr_valid = 1'b1; hdr_in = a;
        @(negedge clk); hdr_in = b;
        repeat (3) begin
            @(negedge clk);
            check("R9 hold req", 32'(port_req), 32'(exp_port(a)));
            check("R9 hold hdr", 32'(hdr_out), 32'(exp_hdr(a)));
        end
        // R10: ack together with a strobe replaces the held result
        ack = 1'b1;
        @(negedge clk);
        hdr_valid = 1'b0; ack = 1'b0;
        check("R10 replace req", 32'(port_req), 32'(exp_port(b)));
        check("R10 replace hdr", 32'(hdr_out), 32'(exp_hdr(b)));
        ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        check("R10 clear after replace", {11'd0, port_req, hdr_out}, 32'd0);

        // Random headers across the full offset range
        for (int i = 0; i < 400; i++) begin
            send(16'($urandom()));
            repeat ($urandom_range(0, 2)) @(negedge clk);
        end

        // R11: reset in the middle of a held result
        @(negedge clk); hdr_valid = 1'b1; hdr_in = 16'h1234;
        @(negedge clk); hdr_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check("R11 mid reset", {11'd0, port_req, hdr_out}, 32'd0);
        rst_n = 1'b1;

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule